// File: doc/BRIEF.md
# Decimated Waveform Sample Capture

This block takes signed two's complement 24-bit samples from two measurement channels, A and B. A strobe marks each sample at the base rate, at most the base clock divided by 160. A 2-bit rate code thins the stream to one output sample in every 1, 2, 4 or 8 base samples. For 25.6 kSPS in, this gives 25.6, 12.8, 6.4 or 3.2 kSPS out. On each output sample, every waveform slot copies the channel its source bit selects, and a sticky status flag is set. The interrupt line is that flag gated by an enable bit. The capture only observes the sample stream and feeds nothing back, so the downstream power and energy arithmetic runs undisturbed.

A host reaches the block through a byte-wide register interface. Reading a slot's high byte returns the high byte of the newest output sample. The same read also copies all 24 bits into a snapshot. The low and middle byte addresses return that snapshot, so a read of high, then low, then middle gives bytes from one sample, even if newer samples arrive between the reads.

Register map (bus_addr): 0 = control (bits 1:0 rate code, bit 2 slot 0 source, bit 3 slot 1 source, bit 7 interrupt enable, bits 6:4 read 0); 1 = status (bit 0 sample flag); 2/3/4 = slot 0 low/middle/high byte; 5/6/7 = slot 1 low/middle/high byte. Other addresses read 0.

Top module: `wav_capture`

## Requirements
- R1: After reset the control register, the status flag and all slot bytes read 0 and irq is low.
- R2: Rate code 00, 01, 10 and 11 produces one output sample per 1, 2, 4 and 8 strobed base samples respectively, the first on the Nth strobe after reset or restart; each output sample sets status bit 0 at the clock edge of that strobe.
- R3: A control write whose rate code differs from the current one restarts decimation, so the next output sample falls on the Nth strobe after that write.
- R4: Source bit 0 selects channel A and 1 selects channel B for that slot; a slot changes only on an output sample, and strobes that produce no output sample leave it unchanged.
- R5: Reading a slot's high byte (address 4 or 7) returns bits 23:16 of its newest output sample and latches all 24 bits; its low (2 or 5) and middle (3 or 6) addresses return bits 7:0 and 15:8 of that latched value.
- R6: Output samples arriving after a high-byte read do not alter the low and middle bytes until the next high-byte read of that slot.
- R7: Status bit 0 stays set until a write to address 1 with data bit 0 = 1; a write there with bit 0 = 0 leaves it set.
- R8: A clear write in the same cycle as an output sample leaves status bit 0 set.
- R9: irq equals status bit 0 AND control bit 7.
- R10: The control register reads back what was written, with bits 6:4 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Strobe marking one base-rate sample on both channels |
| ch_a_samp | input | 24 | Channel A sample, two's complement |
| ch_b_samp | input | 24 | Channel B sample, two's complement |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; on a high-byte address it latches the snapshot |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
All four rate codes are swept, each through eight strobes with distinct data. Each strobe's data differs per rate and per strobe, so an output sample on the wrong strobe, or a copy from the wrong channel, shows up as a wrong byte. Skipped strobes are followed by a high-byte read, which separates "held the previous output sample" from "followed the input". Reads of high, then low, with a new output sample between them separate snapshot behaviour from live reads. A clear that collides with an output sample, a clear with bit 0 zero, and a rate change in the middle of a count each test one ordering rule on its own.

// File: rtl/wav_cap_pkg.sv
package wav_cap_pkg;
    localparam int SAMP_W    = 24;
    localparam int NBYTE     = SAMP_W / 8;
    localparam int NUM_SLOT  = 2;
    localparam int CNT_W     = 3;
    localparam int A_CTRL    = 0;
    localparam int A_STAT    = 1;
    localparam int A_SLOT0   = 2;

    typedef logic [SAMP_W-1:0] samp_t;

    typedef enum logic [1:0] {
        RATE_DIV1 = 2'b00,
        RATE_DIV2 = 2'b01,
        RATE_DIV4 = 2'b10,
        RATE_DIV8 = 2'b11
    } rate_e;

    typedef struct packed {
        logic                irq_en;
        logic [2:0]          rsvd;
        logic [NUM_SLOT-1:0] src;
        rate_e               rate;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] last_count(rate_e r);
        return CNT_W'((1 << r) - 1);
    endfunction

    function automatic int slot_addr(int slot, int byte_idx);
        return A_SLOT0 + slot * NBYTE + byte_idx;
    endfunction
endpackage

// File: rtl/wav_decim.sv
module wav_decim
    import wav_cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  rate_e rate,
    input  logic  restart,
    output logic  out_evt
);
    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last = (cnt == last_count(rate));
    assign out_evt = in_valid && at_last && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (in_valid) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_count(rate));
    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));
endmodule

// File: rtl/wav_slot.sv
module wav_slot
    import wav_cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  evt,
    input  logic  src_b,
    input  samp_t ch_a,
    input  samp_t ch_b,
    input  logic  take,
    output samp_t live,
    output samp_t snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            snap <= '0;
        end else begin
            if (evt)  live <= src_b ? ch_b : ch_a;
            if (take) snap <= live;
        end
    end

    p_live_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(live));
    p_snap_take_r5: assert property (@(posedge clk) disable iff (rst)
        take |=> (snap == $past(live)));
    p_snap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(snap));
endmodule

// File: rtl/wav_capture.sv
module wav_capture
    import wav_cap_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_valid,
    input  logic [SAMP_W-1:0] ch_a_samp,
    input  logic [SAMP_W-1:0] ch_b_samp,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    ctrl_t ctrl;
    logic  status;
    logic  evt;
    logic  restart;
    logic  wr_ctrl;
    logic  clr_stat;
    samp_t live [NUM_SLOT];
    samp_t snap [NUM_SLOT];

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    assign clr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT)) && bus_wdata[0];
    assign restart  = wr_ctrl && (bus_wdata[1:0] != ctrl.rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl      <= ctrl_t'(bus_wdata);
            ctrl.rsvd <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           status <= 1'b0;
        else if (evt)      status <= 1'b1;
        else if (clr_stat) status <= 1'b0;
    end

    assign irq = status && ctrl.irq_en;

    wav_decim u_decim (
        .clk      (clk),
        .rst      (rst),
        .in_valid (samp_valid),
        .rate     (ctrl.rate),
        .restart  (restart),
        .out_evt  (evt)
    );

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        logic take;
        assign take = bus_rd && (bus_addr == ADDR_W'(slot_addr(s, NBYTE - 1)));
        wav_slot u_slot (
            .clk   (clk),
            .rst   (rst),
            .evt   (evt),
            .src_b (ctrl.src[s]),
            .ch_a  (ch_a_samp),
            .ch_b  (ch_b_samp),
            .take  (take),
            .live  (live[s]),
            .snap  (snap[s])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = ctrl;
        if (bus_addr == ADDR_W'(A_STAT)) bus_rdata = {7'b0, status};
        for (int s = 0; s < NUM_SLOT; s++) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (bus_addr == ADDR_W'(slot_addr(s, b))) begin
                    bus_rdata = (b == NBYTE - 1) ? live[s][8*b +: 8]
                                                 : snap[s][8*b +: 8];
                end
            end
        end
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (status && !clr_stat) |=> status);
    p_collide_r8: assert property (@(posedge clk) disable iff (rst)
        evt |=> status);
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !status |-> !irq);
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
        ctrl.rsvd == 3'b000);
endmodule

// File: tb/wav_capture_test.sv
module wav_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        samp_valid = 1'b0;
    logic [23:0] ch_a_samp = '0;
    logic [23:0] ch_b_samp = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wav_capture uut (
        .clk(clk), .rst(rst), .samp_valid(samp_valid),
        .ch_a_samp(ch_a_samp), .ch_b_samp(ch_b_samp),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [23:0] a, input logic [23:0] b);
        @(negedge clk);
        samp_valid = 1'b1; ch_a_samp = a; ch_b_samp = b;
        @(posedge clk);
        @(negedge clk);
        samp_valid = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [7:0] d);
        @(negedge clk);
        bus_addr = 4'(addr); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [7:0] d);
        @(negedge clk);
        bus_addr = 4'(addr); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input int addr, input logic [7:0] exp, input string req);
        logic [7:0] d;
        rd(addr, d);
        chk(d == exp, req, d, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] a, b, last_a, last_b, old_a;
        logic [7:0]  d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd_chk(0, 8'h00, "R1 ctrl");
        rd_chk(1, 8'h00, "R1 status");
        chk(irq == 1'b0, "R1 irq", irq, 0);
        rd_chk(4, 8'h00, "R1 slot0 high");
        rd_chk(2, 8'h00, "R1 slot0 low");
        rd_chk(6, 8'h00, "R1 slot1 mid");

        // R2/R4/R5 sweep over all rate codes
        last_a = '0; last_b = '0;
        for (int code = 0; code < 4; code++) begin
            int ratio;
            ratio = 1 << code;
            wr(0, {6'b000010, 2'(code)});
            rd_chk(0, {6'b000010, 2'(code)}, "R10 ctrl readback");
            wr(1, 8'h01);
            for (int k = 1; k <= 8; k++) begin
                bit exp_evt;
                a = {8'(8'h80 + code*16 + k), 8'(8'h40 + k), 8'(k*3 + code)};
                b = ~a;
                push(a, b);
                exp_evt = (k % ratio) == 0;
                rd(1, d);
                chk(d[0] == exp_evt, "R2 output sample on Nth strobe", d[0], exp_evt);
                if (exp_evt) begin
                    last_a = a; last_b = b;
                    rd_chk(4, a[23:16], "R5 slot0 high (src A)");
                    rd_chk(2, a[7:0],   "R5 slot0 low");
                    rd_chk(3, a[15:8],  "R5 slot0 mid");
                    rd_chk(7, b[23:16], "R4 slot1 high (src B)");
                    rd_chk(5, b[7:0],   "R4 slot1 low");
                    rd_chk(6, b[15:8],  "R5 slot1 mid");
                    wr(1, 8'h01);
                end else begin
                    rd_chk(4, last_a[23:16], "R4 skipped strobe ignored");
                    rd_chk(2, last_a[7:0],   "R4 skipped strobe low");
                end
            end
        end

        // R6 snapshot holds across a new output sample
        wr(0, 8'h00);
        old_a = last_a;
        a = 24'h123456; b = 24'hFEDCBA;
        rd_chk(4, old_a[23:16], "R6 latch old");
        push(a, b);
        rd_chk(2, old_a[7:0],  "R6 low holds old");
        rd_chk(3, old_a[15:8], "R6 mid holds old");
        rd_chk(4, 8'h12, "R6 high shows new");
        rd_chk(2, 8'h56, "R6 low after relatch");
        rd_chk(3, 8'h34, "R6 mid after relatch");
        wr(1, 8'h01);

        // R3 rate change restarts decimation
        wr(0, 8'h03);
        for (int k = 0; k < 5; k++) push(24'h000100 + 24'(k), 24'h0);
        wr(1, 8'h01);
        wr(0, 8'h01);
        push(24'h0A0B0C, 24'h0);
        rd_chk(1, 8'h00, "R3 first strobe after restart");
        push(24'h0D0E0F, 24'h0);
        rd_chk(1, 8'h01, "R3 second strobe after restart");
        rd_chk(4, 8'h0D, "R3 restarted sample");

        // R4 source swap: slot0 from B, slot1 from A
        wr(0, 8'h04 | 8'h00);
        wr(1, 8'h01);
        push(24'hAABBCC, 24'h112233);
        rd_chk(4, 8'h11, "R4 slot0 from B");
        rd_chk(7, 8'hAA, "R4 slot1 from A");

        // R7 sticky status
        rd_chk(1, 8'h01, "R7 set");
        wr(1, 8'h00);
        rd_chk(1, 8'h01, "R7 write zero ignored");
        wr(1, 8'h01);
        rd_chk(1, 8'h00, "R7 cleared");

        // R8 clear colliding with output sample
        @(negedge clk);
        samp_valid = 1'b1; ch_a_samp = 24'h010203; ch_b_samp = 24'h0;
        bus_addr = 4'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        samp_valid = 1'b0; bus_wr = 1'b0;
        rd_chk(1, 8'h01, "R8 collision keeps status");

        // R9 interrupt gating
        chk(irq == 1'b0, "R9 irq off when disabled", irq, 0);
        wr(0, 8'h80);
        chk(irq == 1'b1, "R9 irq on", irq, 1);
        rd_chk(0, 8'h80, "R10 enable readback");
        wr(1, 8'h01);
        chk(irq == 1'b0, "R9 irq drops on clear", irq, 0);
        wr(0, 8'hF0);
        rd_chk(0, 8'h80, "R10 reserved bits read 0");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule